// File: doc/BRIEF.md
# Delayed Write Target with Data Parity Handling

This block is the target side of a bridge that posts delayed writes. When an initiator starts a delayed write (an I/O write or configuration write), the block captures the address, command, address parity, first data word, byte enables and data parity into a single-entry delayed-transaction slot. It then answers with a retry, so the initiator comes back later while the bridge completes the write on the far bus. Completing the write on the far bus lies outside this block. That logic tells the block the slot is free by pulsing `dwr_done`.

The block also checks the data parity of each delayed write request. If a parity error is found and parity-error response is enabled, the block accepts the data and throws it away. It asserts the ready strobe, adds a stop strobe when the initiator wants more than one data phase, and pulls the parity-error strobe low two cycles later. If response is disabled, the request is treated as clean: it is retried and queued. In both cases a sticky detected-parity-error status bit is set.

Bus timing, counted from the address phase (cycle 0): the first data phase is cycle 1, data parity is presented in cycle 2, and the target answers in cycle 3. A data phase is complete when the ready strobe is low in cycle 3. If there is a parity-error indication for that data, it appears in cycle 5.

Top module: `dwr_parity_target`

## Requirements
- R1: While and after reset, `trdy_n`, `stop_n` and `perr_n` are high, and `q_valid` and `det_perr` are low.
- R2: An address phase is a cycle with `frame_n` low after a cycle with `frame_n` high, while the block is idle. Only commands 4'b0011 and 4'b1011 on `cbe_n` are delayed writes. A request with any other command gets no response and changes no state.
- R3: A clean delayed write that finds the slot free is captured, and cycle 3 shows a retry (`stop_n` low, `trdy_n` high). From cycle 3, `q_valid` is high, and the slot holds the address and command from cycle 0, the data and `cbe_n` byte enables from cycle 1, the `par` value of cycle 1 as address parity, and the `par` value of cycle 2 as data parity.
- R4: Parity is even. The data is in error when the XOR of the 32 data bits, the 4 byte-enable bits and the `par` bit of cycle 2 is 1.
- R5: On a data parity error with `perr_resp_en` high, cycle 3 shows `trdy_n` low, and nothing is queued: the slot contents and `q_valid` do not change. `stop_n` is also low in cycle 3 if `frame_n` was still low in cycle 1 (a multi-phase request). Otherwise `stop_n` stays high.
- R6: `perr_n` goes low for exactly cycle 5 after an accepted-with-error request, and at no other time.
- R7: On a data parity error with `perr_resp_en` low, the block retries and queues the request as for a clean write, and `perr_n` stays high.
- R8: `det_perr` is set by any data parity error on a delayed write, whatever the value of `perr_resp_en`. It stays set until `det_clr` is pulsed. If a set and a clear fall on the same edge, the set wins.
- R9: While the slot is valid, every delayed write is retried without being captured and leaves the slot unchanged. This holds both for a re-attempt that matches the queued address, command and byte enables and for a different request.
- R10: A `dwr_done` pulse clears `q_valid` from the next cycle. If `dwr_done` is high in cycle 2 of a clean request, the slot counts as free, and the new request is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Initiator cycle-frame strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| ad | input | 32 | Multiplexed address/data |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| par | input | 1 | Even parity over ad and cbe_n, lagging by one cycle |
| perr_resp_en | input | 1 | Parity-error response enable |
| dwr_done | input | 1 | Queued write finished on the far bus; frees the slot |
| det_clr | input | 1 | Clears the detected-parity-error status bit |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop (retry or disconnect), active low |
| perr_n | output | 1 | Data parity error report, active low |
| q_valid | output | 1 | Delayed-transaction slot holds an entry |
| q_addr | output | 32 | Queued address |
| q_cmd | output | 4 | Queued command |
| q_apar | output | 1 | Queued address parity |
| q_data | output | 32 | Queued write data |
| q_be_n | output | 4 | Queued byte enables, active low |
| q_dpar | output | 1 | Queued data parity |
| det_perr | output | 1 | Sticky detected-parity-error status |

## Verification
Two pairs of events can land on the same clock edge. The first is freeing the slot and capturing a new request: the bench pulses `dwr_done` in cycle 2 of a clean request while the slot is full and expects the new fields to be held from cycle 3. The second is setting and clearing the status bit: the bench sends a request with a parity error and pulses `det_clr` in the same cycle 2, and it expects `det_perr` to stay high. A reference model in the bench predicts every output for each cycle, and the bench compares against it on every clock.

// File: rtl/dwr_parity_target.sv
module dwr_parity_target #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [DW-1:0] ad,
  input  logic [3:0]    cbe_n,
  input  logic          par,
  input  logic          perr_resp_en,
  input  logic          dwr_done,
  input  logic          det_clr,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          perr_n,
  output logic          q_valid,
  output logic [DW-1:0] q_addr,
  output logic [3:0]    q_cmd,
  output logic          q_apar,
  output logic [DW-1:0] q_data,
  output logic [3:0]    q_be_n,
  output logic          q_dpar,
  output logic          det_perr
);
  localparam logic [3:0] CMD_IOW  = 4'b0011;
  localparam logic [3:0] CMD_CFGW = 4'b1011;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_PAR, S_RESP} st_t;
  st_t st;

  logic          frame_q, h_multi, h_apar, perr_s1;
  logic [DW-1:0] h_addr, h_data;
  logic [3:0]    h_cmd, h_be;

  wire is_dw   = (cbe_n == CMD_IOW) || (cbe_n == CMD_CFGW);
  wire addr_ph = (st == S_IDLE) && frame_q && !frame_n;
  wire derr    = ^{h_data, h_be, par};
  wire drop    = derr && perr_resp_en;
  wire in_par  = (st == S_PAR);
  wire take    = in_par && !drop && (!q_valid || dwr_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      frame_q <= 1'b1;
      h_addr  <= '0;
      h_cmd   <= '0;
      h_data  <= '0;
      h_be    <= '0;
      h_apar  <= 1'b0;
      h_multi <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (st)
        S_IDLE: if (addr_ph && is_dw) begin
          st     <= S_DATA;
          h_addr <= ad;
          h_cmd  <= cbe_n;
        end
        S_DATA: begin
          st      <= S_PAR;
          h_data  <= ad;
          h_be    <= cbe_n;
          h_apar  <= par;
          h_multi <= !frame_n;
        end
        S_PAR:   st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trdy_n  <= 1'b1;
      stop_n  <= 1'b1;
      perr_s1 <= 1'b0;
      perr_n  <= 1'b1;
    end else begin
      trdy_n  <= !(in_par && drop);
      stop_n  <= !(in_par && (!drop || h_multi));
      perr_s1 <= (st == S_RESP) && !trdy_n && !irdy_n;
      perr_n  <= !perr_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_addr   <= '0;
      q_cmd    <= '0;
      q_apar   <= 1'b0;
      q_data   <= '0;
      q_be_n   <= '0;
      q_dpar   <= 1'b0;
      det_perr <= 1'b0;
    end else begin
      if (take) begin
        q_valid <= 1'b1;
        q_addr  <= h_addr;
        q_cmd   <= h_cmd;
        q_apar  <= h_apar;
        q_data  <= h_data;
        q_be_n  <= h_be;
        q_dpar  <= par;
      end else if (dwr_done) begin
        q_valid <= 1'b0;
      end
      if (in_par && derr)
        det_perr <= 1'b1;
      else if (det_clr)
        det_perr <= 1'b0;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> trdy_n && stop_n && perr_n && !q_valid);
  // R3
  retry_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n) (!stop_n && trdy_n) |-> q_valid);
  // R5
  drop_keeps_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && !$past(dwr_done)) |-> (q_valid == $past(q_valid)) && $stable(q_addr) && $stable(q_data));
  // R6
  perr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(perr_n) |=> perr_n);
  // R6
  perr_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) !perr_n |-> $past(!trdy_n, 2));
  // R8
  det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (det_perr && !det_clr) |=> det_perr);
  // R9
  busy_slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(q_valid) && q_valid && !$past(dwr_done)) |-> $stable(q_addr) && $stable(q_cmd) && $stable(q_be_n));
endmodule

// File: tb/sim_dwr_parity_target.sv
module sim_dwr_parity_target;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, par = 1'b0, perr_resp_en = 1'b1;
  logic dwr_done = 1'b0, det_clr = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '0;
  logic trdy_n, stop_n, perr_n, q_valid, q_apar, q_dpar, det_perr;
  logic [31:0] q_addr, q_data;
  logic [3:0]  q_cmd, q_be_n;

  dwr_parity_target u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit cmp_on = 0;
  string cur = "R1";

  logic e_trdy = 1, e_stop = 1, e_perr = 1, e_qv = 0, e_det = 0;
  logic [31:0] e_addr, e_data;
  logic [3:0]  e_cmd, e_be;
  logic e_apar, e_dpar;

  task automatic fail1(string what, logic [31:0] act, logic [31:0] exp);
    miscompares++;
    $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
  endtask

  always @(negedge clk) if (cmp_on) begin
    vectors++;
    if (trdy_n !== e_trdy)   fail1("trdy_n", 32'(trdy_n), 32'(e_trdy));
    if (stop_n !== e_stop)   fail1("stop_n", 32'(stop_n), 32'(e_stop));
    if (perr_n !== e_perr)   fail1("perr_n", 32'(perr_n), 32'(e_perr));
    if (q_valid !== e_qv)    fail1("q_valid", 32'(q_valid), 32'(e_qv));
    if (det_perr !== e_det)  fail1("det_perr", 32'(det_perr), 32'(e_det));
    if (e_qv) begin
      if (q_addr !== e_addr) fail1("q_addr", q_addr, e_addr);
      if (q_cmd  !== e_cmd)  fail1("q_cmd", 32'(q_cmd), 32'(e_cmd));
      if (q_data !== e_data) fail1("q_data", q_data, e_data);
      if (q_be_n !== e_be)   fail1("q_be_n", 32'(q_be_n), 32'(e_be));
      if (q_apar !== e_apar) fail1("q_apar", 32'(q_apar), 32'(e_apar));
      if (q_dpar !== e_dpar) fail1("q_dpar", 32'(q_dpar), 32'(e_dpar));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [31:0] a, input logic [3:0] cmd, input logic [3:0] be,
                      input logic [31:0] d, input bit multi, input bit bad,
                      input bit done_c2, input bit clr_c2);
    bit dw = (cmd == 4'b0011) || (cmd == 4'b1011);
    bit err, drop, free;
    logic dp;
    cyc();
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = cmd;
    cyc();
    frame_n = !multi; irdy_n = 1'b0; ad = d; cbe_n = be; par = ^{a, cmd};
    cyc();
    dp = (^{d, be}) ^ bad;
    par = dp; dwr_done = done_c2; det_clr = clr_c2;
    cyc();
    dwr_done = 1'b0; det_clr = 1'b0; frame_n = 1'b1;
    err  = dw && bad;
    drop = err && perr_resp_en;
    free = !e_qv || done_c2;
    if (dw) begin
      e_trdy = !drop;
      e_stop = !(!drop || multi);
      if (!drop && free) begin
        e_qv = 1; e_addr = a; e_cmd = cmd; e_data = d; e_be = be;
        e_apar = ^{a, cmd}; e_dpar = dp;
      end else if (done_c2) e_qv = 0;
      if (err) e_det = 1;
      else if (clr_c2) e_det = 0;
    end else begin
      if (done_c2) e_qv = 0;
      if (clr_c2) e_det = 0;
    end
    cyc();
    irdy_n = 1'b1; e_trdy = 1; e_stop = 1;
    cyc();
    if (drop) e_perr = 0;
    cyc();
    e_perr = 1;
    cyc();
  endtask

  task automatic pulse_done();
    cyc(); dwr_done = 1'b1;
    cyc(); dwr_done = 1'b0; e_qv = 0;
    cyc();
  endtask

  task automatic pulse_clr();
    cyc(); det_clr = 1'b1;
    cyc(); det_clr = 1'b0; e_det = 0;
    cyc();
  endtask

  initial begin
    cur = "R1";
    cyc();
    cmp_on = 1;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (3) cyc();

    cur = "R3"; perr_resp_en = 1;
    send(32'h1000_0040, 4'b0011, 4'b0000, 32'hDEAD_BEEF, 0, 0, 0, 0);
    cur = "R9";
    send(32'h1000_0040, 4'b0011, 4'b0000, 32'h1234_5678, 0, 0, 0, 0);
    send(32'h2000_0000, 4'b1011, 4'b1100, 32'h0F0F_0F0F, 1, 0, 0, 0);
    cur = "R10";
    pulse_done();

    cur = "R5";
    send(32'h3000_0004, 4'b0011, 4'b0001, 32'hAAAA_5555, 0, 1, 0, 0);
    send(32'h3000_0008, 4'b1011, 4'b0000, 32'h8000_0001, 1, 1, 0, 0);
    cur = "R6";
    pulse_clr();

    cur = "R7"; perr_resp_en = 0;
    send(32'h4000_0010, 4'b0011, 4'b0110, 32'h0000_00FF, 1, 1, 0, 0);
    cur = "R8";
    pulse_clr();
    send(32'h4000_0020, 4'b1011, 4'b0000, 32'h1111_1111, 0, 1, 0, 0);

    cur = "R2"; perr_resp_en = 1;
    send(32'h5000_0000, 4'b0111, 4'b0000, 32'h2222_2222, 0, 1, 0, 0);
    send(32'h5000_0000, 4'b0110, 4'b0000, 32'h2222_2222, 0, 0, 0, 0);

    cur = "R10";
    send(32'h6000_0000, 4'b1011, 4'b1010, 32'hCAFE_F00D, 0, 0, 1, 0);

    cur = "R8";
    send(32'h7000_0000, 4'b0011, 4'b0000, 32'h0000_0001, 0, 1, 0, 1);
    pulse_done();

    cur = "R4";
    send(32'h7000_0100, 4'b0011, 4'b1111, 32'hFFFF_FFFF, 0, 0, 0, 0);
    pulse_done();
    send(32'h7000_0200, 4'b0011, 4'b0000, 32'h0000_0000, 0, 1, 0, 0);
    repeat (3) cyc();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule